// File: doc/BRIEF.md
# Chained Configuration Responder for a Memory Expansion

This block lets a 16-bit memory expansion on a 68000-style asynchronous bus take part in the automatic configuration daisy chain. While the chain enables it, the block answers reads in the configuration window at `$E8xxxx` with a short board description. Each description byte is spread across two word addresses, one nibble per word, on the top four data lines. The CPU then either assigns a base address or tells the board to shut up. In both cases the block leaves the window until the next reset and pulls its chain output low, which enables the next device in the chain.

Once a base address is assigned, the block asserts a RAM select for accesses that fall inside the assigned range. It also terminates those accesses with a data acknowledge. A deferred mode is available for systems where another configurable device is fixed first in line and the chain input cannot be used. In that mode the block ignores its chain input. It watches the window for one other device to finish configuring, and only then starts answering as the configuring device. Indivisible read-modify-write bus cycles get no special handling.

The bus strobes and chain input are brought into the clock domain by a synchronizer. Address, direction and write data are taken as stable while the synchronized address strobe is low.

Top module: `acfg_responder`

## Requirements
- R1: In normal mode (`defer_mode`=0), an access to the window (address bits 23..16 equal to `$E8`) gets an acknowledge and data-bus drive only while `cfg_in_n` is low. With `cfg_in_n` high, `dtack_n` stays high and `data_oe` stays low.
- R2: A window read at byte offset 2*k returns identification nibble k on `data_nib` (the data bus bits 15..12). Byte register r occupies offsets 4r (high nibble) and 4r+2 (low nibble). The register values are: r0 = `{4'hE, 1'b0, size}`, where size = (5 + log2(RAM_BLOCKS)) mod 8; r1 = PRODUCT_ID; r4/r5 = MFR_ID high/low byte; r6..r9 = SERIAL_NO from the most significant byte down; every other register is 0. Nibbles of r0 are returned as is, and all other nibbles are returned inverted.
- R3: After a base or shut-up write has been accepted, no window access is acknowledged until reset.
- R4: `cfg_out_n` goes low when a base or shut-up write is accepted, and stays low until reset.
- R5: `ram_sel_n` is low during an access only if a base nibble B has been assigned and address bits 23..20 lie in [B, B+RAM_BLOCKS). Such accesses are acknowledged. Every other access leaves `ram_sel_n` high.
- R6: A window write at byte offset `$48` assigns the base nibble from `wr_nib`. A write at `$4C` is the shut-up command. Writes to any other window offset leave `cfg_out_n` high and the window still answering.
- R7: After a shut-up, `ram_sel_n` never goes low until reset.
- R8: After reset, `cfg_out_n`, `dtack_n` and `ram_sel_n` are high and `data_oe` is low, in both modes.
- R9: `dtack_n`, once low, is released (high) within three clock cycles after `as_n` rises.
- R10: With `defer_mode`=1, `cfg_in_n` is ignored. The window stays silent until one write by another device at offset `$48` or `$4C` has been seen. From then on the block answers and configures as in R2, R3, R4 and R6. A write by another device at any other offset does not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| defer_mode | input | 1 | 1 = self-enable after one other device configures |
| as_n | input | 1 | Bus address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 23 | Bus address bits 23..1 |
| wr_nib | input | 4 | Write data bus bits 15..12 |
| cfg_in_n | input | 1 | Chain enable input, active low |
| data_nib | output | 4 | Read data for bus bits 15..12 |
| data_oe | output | 1 | Drive enable for the read data |
| dtack_n | output | 1 | Data acknowledge, active low |
| cfg_out_n | output | 1 | Chain enable output, active low |
| ram_sel_n | output | 1 | RAM select for the assigned range, active low |

## Verification
The bench aims at the points where the chain can break. It checks silence in the window while the chain input is high: a broken block would answer together with another card. It checks the inverted/non-inverted split at nibble boundaries, where a wrong split would misreport the board type. It checks that the block leaves the window after the configuring write, so that a late answer would clash with the next card. It tests range edges one word either side of the assigned block, where an off-by-one would claim a neighbour's access. In deferred mode it checks that a write at an unrelated window offset does not count as the other device's completion, and that the counted write itself is not acknowledged by this block.

// File: rtl/acfg_pkg.sv
// Package: shared constants and helpers for the chained configuration responder.
// Assumes a 24-bit bus address space with a 64 KiB configuration window.
package acfg_pkg;

    // Address bits 23..16 that select the configuration window.
    localparam logic [7:0] WINDOW_PAGE = 8'hE8;

    // Word index (byte offset / 2) of the base-address register write.
    localparam logic [6:0] BASE_WORD = 7'h24;

    // Word index of the shut-up command write.
    localparam logic [6:0] SHUT_WORD = 7'h26;

    // Encodes the board size for a power-of-two count of 1 MiB blocks.
    function automatic logic [2:0] size_code(input int blocks_log2);
        return 3'((5 + blocks_log2) % 8);
    endfunction

endpackage

// File: rtl/acfg_bus_sync.sv
// Module: acfg_bus_sync
// Brings the asynchronous strobes and the chain input into the clock domain
// through STAGES flops each. It also presents the previous synchronized
// address strobe so the caller can detect the start of an access.
// Assumes every input is level-significant, with no glitch shorter than a clock.
module acfg_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic uds_n,
    input  logic lds_n,
    input  logic cfg_in_n,
    output logic as_ns,
    output logic as_ns_d,
    output logic uds_ns,
    output logic lds_ns,
    output logic cfg_in_ns
);

    localparam int NSIG = 4;

    logic [NSIG-1:0] stage_q [STAGES];

    // Synchronizer chain: stage 0 captures pins, later stages follow.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= {cfg_in_n, lds_n, uds_n, as_n};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized strobe, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) as_ns_d <= 1'b1;
        else        as_ns_d <= stage_q[STAGES-1][0];
    end

    assign as_ns     = stage_q[STAGES-1][0];
    assign uds_ns    = stage_q[STAGES-1][1];
    assign lds_ns    = stage_q[STAGES-1][2];
    assign cfg_in_ns = stage_q[STAGES-1][3];

endmodule

// File: rtl/acfg_id_rom.sv
// Module: acfg_id_rom
// Combinational board-description table. It maps a window word offset to the
// identification nibble. Nibbles of register 0 are returned true, and all
// others are returned inverted. Offsets outside the first 256 bytes read as
// register value 0.
module acfg_id_rom #(
    parameter logic [7:0]  PRODUCT_ID = 8'h5A,
    parameter logic [15:0] MFR_ID     = 16'h0A3C,
    parameter logic [31:0] SERIAL_NO  = 32'h1234_5678,
    parameter int          RAM_BLOCKS = 8
) (
    input  logic [14:0] word_ofs,
    output logic [3:0]  nib
);
    import acfg_pkg::*;

    localparam int         BLK_LOG2 = $clog2(RAM_BLOCKS);
    localparam logic [2:0] SIZE     = size_code(BLK_LOG2);

    logic [5:0] reg_idx;
    logic [7:0] reg_byte;
    logic [3:0] raw_nib;

    assign reg_idx = word_ofs[6:1];

    // Register contents for the selected byte register.
    always_comb begin
        reg_byte = 8'h00;
        if (word_ofs[14:7] == 8'h00) begin
            case (reg_idx)
                6'd0: reg_byte = {4'hE, 1'b0, SIZE};
                6'd1: reg_byte = PRODUCT_ID;
                6'd4: reg_byte = MFR_ID[15:8];
                6'd5: reg_byte = MFR_ID[7:0];
                6'd6: reg_byte = SERIAL_NO[31:24];
                6'd7: reg_byte = SERIAL_NO[23:16];
                6'd8: reg_byte = SERIAL_NO[15:8];
                6'd9: reg_byte = SERIAL_NO[7:0];
                default: reg_byte = 8'h00;
            endcase
        end
    end

    // Nibble select (even word = high) and inversion for registers past the first.
    always_comb begin
        raw_nib = word_ofs[0] ? reg_byte[3:0] : reg_byte[7:4];
        nib     = (reg_idx == 6'd0) ? raw_nib : ~raw_nib;
    end

endmodule

// File: rtl/acfg_chain_ctrl.sv
// Module: acfg_chain_ctrl
// Configuration state machine. It decides whether the block owns a window
// access, latches the base nibble or the shut-up command, drives the chain
// output, and in deferred mode counts one other device's configuring write.
// Assumes address, direction and write data are stable while the access runs.
module acfg_chain_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       defer_mode,
    input  logic       cfg_in_ns,
    input  logic       acc_start,
    input  logic       acc_active,
    input  logic       upper_ds,
    input  logic       rw,
    input  logic       in_window,
    input  logic       ofs_hi_zero,
    input  logic [6:0] ofs_word,
    input  logic [3:0] wr_nib,
    output logic       win_claimed,
    output logic       cfg_done,
    output logic       base_valid,
    output logic [3:0] base_nib,
    output logic       cfg_out_n
);
    import acfg_pkg::*;

    logic enable;
    logic defer_seen;
    logic wr_taken;
    logic is_base_ofs;
    logic is_shut_ofs;
    logic win_write;
    logic own_write;
    logic other_write;

    // Whether the block may claim a window access that starts now.
    always_comb begin
        if (defer_mode) enable = defer_seen & ~cfg_done;
        else            enable = ~cfg_in_ns & ~cfg_done;
    end

    // Decode of the two configuring register offsets and of write strobes.
    always_comb begin
        is_base_ofs = ofs_hi_zero && (ofs_word == BASE_WORD);
        is_shut_ofs = ofs_hi_zero && (ofs_word == SHUT_WORD);
        win_write   = acc_active && !acc_start && in_window && !rw
                      && upper_ds && !wr_taken;
        own_write   = win_write && win_claimed;
        other_write = win_write && !win_claimed && defer_mode && !defer_seen
                      && !cfg_done && (is_base_ofs || is_shut_ofs);
    end

    // Ownership of the current window access, decided at its first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           win_claimed <= 1'b0;
        else if (!acc_active) win_claimed <= 1'b0;
        else if (acc_start)   win_claimed <= in_window && enable;
    end

    // One window write is acted on per access.
    always_ff @(posedge clk) begin
        if (!rst_n)           wr_taken <= 1'b0;
        else if (!acc_active) wr_taken <= 1'b0;
        else if (win_write)   wr_taken <= 1'b1;
    end

    // Deferred mode: remember that another device finished configuring.
    always_ff @(posedge clk) begin
        if (!rst_n)           defer_seen <= 1'b0;
        else if (other_write) defer_seen <= 1'b1;
    end

    // Base assignment, shut-up and chain output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_done   <= 1'b0;
            base_valid <= 1'b0;
            base_nib   <= 4'h0;
            cfg_out_n  <= 1'b1;
        end else if (own_write && is_base_ofs) begin
            cfg_done   <= 1'b1;
            base_valid <= 1'b1;
            base_nib   <= wr_nib;
            cfg_out_n  <= 1'b0;
        end else if (own_write && is_shut_ofs) begin
            cfg_done   <= 1'b1;
            cfg_out_n  <= 1'b0;
        end
    end

    AST_CFGOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_out_n |=> !cfg_out_n); // R4
    AST_BASE_WITH_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        base_valid |-> (cfg_done && !cfg_out_n)); // R4
    AST_NO_CLAIM_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && acc_start) |=> !win_claimed); // R3
    AST_DEFER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_mode && !defer_seen && acc_start) |=> !win_claimed); // R10

endmodule

// File: rtl/acfg_ram_decode.sv
// Module: acfg_ram_decode
// RAM range decoder. After a base nibble is assigned, it claims accesses whose
// top address nibble lies in [base, base+RAM_BLOCKS), with no wrap-around.
// The decision is taken at the start of an access and held until it ends.
module acfg_ram_decode #(
    parameter int RAM_BLOCKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_start,
    input  logic       acc_active,
    input  logic [3:0] addr_nib,
    input  logic       base_valid,
    input  logic [3:0] base_nib,
    output logic       ram_claimed,
    output logic       ram_sel_n
);

    localparam logic [4:0] SPAN = 5'(RAM_BLOCKS);

    logic range_hit;
    logic claim_next;

    // Range compare on 5 bits so a high base cannot wrap to low addresses.
    always_comb begin
        range_hit = base_valid
                    && ({1'b0, addr_nib} >= {1'b0, base_nib})
                    && ({1'b0, addr_nib} <  ({1'b0, base_nib} + SPAN));
        if (!acc_active)    claim_next = 1'b0;
        else if (acc_start) claim_next = range_hit;
        else                claim_next = ram_claimed;
    end

    // Registered claim and select output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_claimed <= 1'b0;
            ram_sel_n   <= 1'b1;
        end else begin
            ram_claimed <= claim_next;
            ram_sel_n   <= ~claim_next;
        end
    end

    AST_SEL_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> base_valid); // R5
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_active |=> ram_sel_n); // R5

endmodule

// File: rtl/acfg_responder.sv
// Module: acfg_responder (top)
// Chained configuration responder for a memory expansion on a 68000-style
// bus. It ties the synchronizer, the description table, the chain state
// machine and the RAM decoder together, and produces the acknowledge and read
// data. Assumes address, rw and wr_nib are stable while as_n is low, and that
// defer_mode changes only during reset.
module acfg_responder #(
    parameter int          SYNC_STAGES = 2,
    parameter int          RAM_BLOCKS  = 8,
    parameter logic [7:0]  PRODUCT_ID  = 8'h5A,
    parameter logic [15:0] MFR_ID      = 16'h0A3C,
    parameter logic [31:0] SERIAL_NO   = 32'h1234_5678
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        defer_mode,
    input  logic        as_n,
    input  logic        uds_n,
    input  logic        lds_n,
    input  logic        rw,
    input  logic [23:1] addr,
    input  logic [3:0]  wr_nib,
    input  logic        cfg_in_n,
    output logic [3:0]  data_nib,
    output logic        data_oe,
    output logic        dtack_n,
    output logic        cfg_out_n,
    output logic        ram_sel_n
);
    import acfg_pkg::*;

    logic       as_ns, as_ns_d, uds_ns, lds_ns, cfg_in_ns;
    logic       acc_start, acc_active, ds_any, in_window;
    logic       win_claimed, cfg_done, base_valid, ram_claimed;
    logic [3:0] base_nib;
    logic [3:0] rom_nib;

    acfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .uds_n     (uds_n),
        .lds_n     (lds_n),
        .cfg_in_n  (cfg_in_n),
        .as_ns     (as_ns),
        .as_ns_d   (as_ns_d),
        .uds_ns    (uds_ns),
        .lds_ns    (lds_ns),
        .cfg_in_ns (cfg_in_ns)
    );

    // Access framing derived from the synchronized strobes.
    always_comb begin
        acc_active = ~as_ns;
        acc_start  = ~as_ns & as_ns_d;
        ds_any     = ~uds_ns | ~lds_ns;
        in_window  = (addr[23:16] == WINDOW_PAGE);
    end

    acfg_id_rom #(
        .PRODUCT_ID (PRODUCT_ID),
        .MFR_ID     (MFR_ID),
        .SERIAL_NO  (SERIAL_NO),
        .RAM_BLOCKS (RAM_BLOCKS)
    ) u_rom (
        .word_ofs (addr[15:1]),
        .nib      (rom_nib)
    );

    acfg_chain_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .defer_mode  (defer_mode),
        .cfg_in_ns   (cfg_in_ns),
        .acc_start   (acc_start),
        .acc_active  (acc_active),
        .upper_ds    (~uds_ns),
        .rw          (rw),
        .in_window   (in_window),
        .ofs_hi_zero (addr[15:8] == 8'h00),
        .ofs_word    (addr[7:1]),
        .wr_nib      (wr_nib),
        .win_claimed (win_claimed),
        .cfg_done    (cfg_done),
        .base_valid  (base_valid),
        .base_nib    (base_nib),
        .cfg_out_n   (cfg_out_n)
    );

    acfg_ram_decode #(.RAM_BLOCKS(RAM_BLOCKS)) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_start   (acc_start),
        .acc_active  (acc_active),
        .addr_nib    (addr[23:20]),
        .base_valid  (base_valid),
        .base_nib    (base_nib),
        .ram_claimed (ram_claimed),
        .ram_sel_n   (ram_sel_n)
    );

    // Acknowledge: set once a claimed access shows a data strobe, cleared when the strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      dtack_n <= 1'b1;
        else if (!acc_active)                            dtack_n <= 1'b1;
        else if ((win_claimed || ram_claimed) && ds_any) dtack_n <= 1'b0;
    end

    // Read data and drive enable for claimed window reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_oe  <= 1'b0;
            data_nib <= 4'h0;
        end else begin
            data_oe  <= acc_active && win_claimed && rw;
            data_nib <= (acc_active && win_claimed && rw) ? rom_nib : 4'h0;
        end
    end

    AST_DTACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_active |=> dtack_n); // R9
    AST_OE_OWNED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (in_window && !cfg_out_n == cfg_done)); // R1

endmodule

// File: tb/acfg_responder_tb.sv
// Bench for acfg_responder: directed chain scenarios mixed with seeded random reads and RAM accesses.
module acfg_responder_tb;

    localparam int          BLOCKS  = 8;
    localparam logic [7:0]  PROD    = 8'h5A;
    localparam logic [15:0] MFR     = 16'h0A3C;
    localparam logic [31:0] SERIAL  = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        defer_mode = 1'b0;
    logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic [23:0] baddr = 24'h0;
    logic [3:0]  wr_nib = 4'h0;
    logic        cfg_in_n = 1'b1;
    logic [3:0]  data_nib;
    logic        data_oe, dtack_n, cfg_out_n, ram_sel_n;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    acfg_responder #(
        .SYNC_STAGES (2),
        .RAM_BLOCKS  (BLOCKS),
        .PRODUCT_ID  (PROD),
        .MFR_ID      (MFR),
        .SERIAL_NO   (SERIAL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .defer_mode (defer_mode),
        .as_n (as_n), .uds_n (uds_n), .lds_n (lds_n), .rw (rw),
        .addr (baddr[23:1]), .wr_nib (wr_nib), .cfg_in_n (cfg_in_n),
        .data_nib (data_nib), .data_oe (data_oe), .dtack_n (dtack_n),
        .cfg_out_n (cfg_out_n), .ram_sel_n (ram_sel_n)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_err++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                report();
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected identification nibble for a window word index (R2).
    function automatic logic [3:0] exp_nib(input int idx);
        logic [7:0] b;
        logic [3:0] n;
        int r;
        r = idx / 2;
        case (r)
            0: b = {4'hE, 1'b0, 3'((5 + $clog2(BLOCKS)) % 8)};
            1: b = PROD;
            4: b = MFR[15:8];
            5: b = MFR[7:0];
            6: b = SERIAL[31:24];
            7: b = SERIAL[23:16];
            8: b = SERIAL[15:8];
            9: b = SERIAL[7:0];
            default: b = 8'h00;
        endcase
        n = (idx % 2 == 1) ? b[3:0] : b[7:4];
        return (r == 0) ? n : ~n;
    endfunction

    // One bus access. acked: dtack seen; rnib: read data; sel: ram_sel_n low seen.
    task automatic bus(input logic [23:0] a, input bit rd, input logic [3:0] wn,
                       output bit acked, output logic [3:0] rnib, output bit sel);
        acked = 1'b0; sel = 1'b0; rnib = 4'h0;
        @(negedge clk);
        baddr = a; rw = rd; wr_nib = wn;
        as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!ram_sel_n) sel = 1'b1;
            if (!dtack_n && !acked) begin
                acked = 1'b1;
                rnib  = data_nib;
            end
        end
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw = 1'b1;
        for (int i = 0; i < 4; i++) @(negedge clk);
        if (acked) check(dtack_n == 1'b1, "R9 dtack release", dtack_n, 1);
    endtask

    task automatic do_reset(input bit dm, input bit cin);
        @(negedge clk);
        rst_n = 1'b0; defer_mode = dm; cfg_in_n = cin;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cfg_out_n && dtack_n && ram_sel_n && !data_oe, "R8 reset state",
              {cfg_out_n, dtack_n, ram_sel_n, data_oe}, 4'b1110);
    endtask

    initial begin
        bit ack, sel;
        logic [3:0] rn;
        void'($urandom(32'd2024));

        // Normal mode, chain input high: window stays silent.
        do_reset(1'b0, 1'b1);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(!ack && !data_oe, "R1 silent with cfg_in high", ack, 0);
        bus(24'hE80004, 1'b1, 4'h0, ack, rn, sel);
        check(!ack, "R1 silent with cfg_in high", ack, 0);

        // Chain enabled: identification reads.
        cfg_in_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            bus(24'hE80000 | 24'(k * 2), 1'b1, 4'h0, ack, rn, sel);
            check(ack && rn == exp_nib(k), "R2 id nibble directed", rn, exp_nib(k));
        end
        for (int k = 0; k < 14; k++) begin
            int idx;
            idx = int'($urandom % 20);
            bus(24'hE80000 | 24'(idx * 2), 1'b1, 4'h0, ack, rn, sel);
            check(ack && rn == exp_nib(idx), "R2 id nibble random", rn, exp_nib(idx));
        end

        // RAM before base assignment: not selected.
        bus(24'h200000, 1'b1, 4'h0, ack, rn, sel);
        check(!sel && !ack, "R5 no select before base", sel, 0);

        // Write at an unrelated offset: no configuration.
        bus(24'hE80040, 1'b0, 4'h3, ack, rn, sel);
        check(cfg_out_n == 1'b1, "R6 other offset ignored", cfg_out_n, 1);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(ack && rn == exp_nib(0), "R6 still answering", rn, exp_nib(0));

        // Base assignment at $48.
        bus(24'hE80048, 1'b0, 4'h2, ack, rn, sel);
        check(ack, "R6 base write acknowledged", ack, 1);
        check(cfg_out_n == 1'b0, "R4 chain out low after base", cfg_out_n, 0);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(!ack, "R3 window left after base", ack, 0);
        cfg_in_n = 1'b1;
        bus(24'hE80002, 1'b1, 4'h0, ack, rn, sel);
        check(!ack && cfg_out_n == 1'b0, "R3 R4 stays configured", ack, 0);

        // Range edges and random RAM accesses.
        bus(24'h1FFFFE, 1'b1, 4'h0, ack, rn, sel);
        check(!sel && !ack, "R5 below range", sel, 0);
        bus(24'h200000, 1'b0, 4'h0, ack, rn, sel);
        check(sel && ack, "R5 range start", sel, 1);
        bus(24'h9FFFFE, 1'b1, 4'h0, ack, rn, sel);
        check(sel && ack, "R5 range end", sel, 1);
        bus(24'hA00000, 1'b1, 4'h0, ack, rn, sel);
        check(!sel && !ack, "R5 above range", sel, 0);
        for (int k = 0; k < 16; k++) begin
            logic [23:0] a;
            bit e;
            a = 24'($urandom) & 24'hFFFFFE;
            e = (a[23:20] >= 4'h2) && (a[23:20] < 4'hA);
            bus(a, 1'($urandom % 2), 4'h0, ack, rn, sel);
            check(sel == e && ack == e, "R5 random ram access", sel, e);
        end

        // Shut-up path.
        do_reset(1'b0, 1'b0);
        bus(24'h200000, 1'b1, 4'h0, ack, rn, sel);
        check(!sel, "R8 base cleared by reset", sel, 0);
        bus(24'hE8004C, 1'b0, 4'h0, ack, rn, sel);
        check(ack && cfg_out_n == 1'b0, "R4 chain out low after shut-up", cfg_out_n, 0);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(!ack, "R3 window left after shut-up", ack, 0);
        for (int k = 0; k < 6; k++) begin
            logic [23:0] a;
            a = 24'($urandom) & 24'hFFFFFE;
            bus(a, 1'b1, 4'h0, ack, rn, sel);
            check(!sel, "R7 no select after shut-up", sel, 0);
        end
        bus(24'h000000, 1'b1, 4'h0, ack, rn, sel);
        check(!sel, "R7 no select at base zero", sel, 0);

        // Deferred mode, chain input low but ignored.
        do_reset(1'b1, 1'b0);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(!ack, "R10 silent before other device", ack, 0);
        bus(24'hE80040, 1'b0, 4'h1, ack, rn, sel);
        check(!ack, "R10 unrelated write not claimed", ack, 0);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(!ack, "R10 unrelated write not counted", ack, 0);
        bus(24'hE80048, 1'b0, 4'h6, ack, rn, sel);
        check(!ack && cfg_out_n == 1'b1, "R10 other device write", {ack, cfg_out_n}, 1);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(ack && rn == exp_nib(0), "R10 answering after other", rn, exp_nib(0));
        bus(24'hE80004, 1'b1, 4'h0, ack, rn, sel);
        check(ack && rn == exp_nib(2), "R10 R2 product nibble", rn, exp_nib(2));
        bus(24'hE80048, 1'b0, 4'h4, ack, rn, sel);
        check(ack && cfg_out_n == 1'b0, "R10 own base write", cfg_out_n, 0);
        bus(24'h400000, 1'b1, 4'h0, ack, rn, sel);
        check(sel && ack, "R10 R5 deferred range hit", sel, 1);
        bus(24'h200000, 1'b1, 4'h0, ack, rn, sel);
        check(!sel, "R10 R5 deferred range miss", sel, 0);

        // Deferred mode: chain input high is ignored too.
        do_reset(1'b1, 1'b1);
        bus(24'hE8004C, 1'b0, 4'h0, ack, rn, sel);
        bus(24'hE80000, 1'b1, 4'h0, ack, rn, sel);
        check(ack && rn == exp_nib(0), "R10 cfg_in high ignored", ack, 1);

        report();
        $finish;
    end

endmodule